// File: doc/BRIEF.md
# Memory Tag Checking Unit

The block guards memory accesses with per-granule allocation tags. It holds a small tag store with one 4-bit tag for each 16-byte granule of a tagged region. A tag-set command paints one tag value over every granule that covers a requested byte range. The command then runs one granule per cycle, and access requests are held off while it runs.

Each load or store request carries a pointer tag in the top byte of its address. The unit compares that tag with the stored tag of each granule the access touches. One cycle after it accepts a request, the unit answers with either "completes" or "trapped".

In synchronous mode, a mismatch traps the access and the unit latches the full faulting address. In asynchronous mode, the access completes anyway and the mismatch sets a sticky flag. Only an explicit clear input resets that flag. A global enable input turns all checking off.

Top module: `tag_check_unit`

## Requirements
- R1: After reset every stored tag is 0, the sticky flag is low and busy is low, so an access whose pointer tag is 0 completes.
- R2: The pointer tag is address bits [59:56]. Address bits [63:60] and all bits between the granule index and bit 56 take no part in selecting the granule. The granule index is address bits [9:4] (64 granules).
- R3: A tag-set command accepted with base offset B and size S>0 writes the tag to ceil(((B mod 16)+S)/16) consecutive granules, starting at granule B/16. Busy is high for exactly that many cycles, beginning in the cycle after acceptance. A size of 0 writes nothing and raises no busy.
- R4: While busy is high, req_ready_o is low and an access request produces no response.
- R5: An accepted access whose pointer tag matches every granule it touches produces rsp_valid_o=1, rsp_ok_o=1 and rsp_fault_o=0 in the following cycle.
- R6: In synchronous mode (sync_mode_i=1), a mismatch produces rsp_valid_o=1, rsp_fault_o=1 and rsp_ok_o=0. fault_addr_o then shows the full request address.
- R7: In asynchronous mode (sync_mode_i=0), a mismatch still gives rsp_ok_o=1 and rsp_fault_o=0, and async_fault_o reads 1 from the following cycle.
- R8: async_fault_o stays high until async_clr_i is high in a cycle. When a new asynchronous mismatch is accepted in that same cycle, the flag stays set.
- R9: An access with length code L (L+1 bytes) whose last byte falls in the next granule must match both granules' tags, else it mismatches.
- R10: An access that stays inside one granule is checked only against that granule, whatever its offset and length.
- R11: With en_i low, every accepted access completes with rsp_ok_o=1, and neither rsp_fault_o nor async_fault_o is raised.
- R12: Granule indices wrap modulo 64, both when a tag-set runs past granule 63 and when an access crosses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global check enable |
| sync_mode_i | input | 1 | 1 = trap on mismatch, 0 = sticky flag only |
| async_clr_i | input | 1 | Clears the sticky flag |
| set_valid_i | input | 1 | Tag-set command request |
| set_base_i | input | 10 | Byte offset of range start within the tagged region |
| set_bytes_i | input | 12 | Range size in bytes |
| set_tag_i | input | 4 | Tag value to write |
| set_busy_o | output | 1 | Tag-set in progress |
| req_valid_i | input | 1 | Access request |
| req_addr_i | input | 64 | Tagged access address |
| req_len_i | input | 4 | Access size minus one, in bytes |
| req_ready_o | output | 1 | Access can be accepted |
| rsp_valid_o | output | 1 | Response for the access accepted last cycle |
| rsp_ok_o | output | 1 | Access completes |
| rsp_fault_o | output | 1 | Access trapped (synchronous mismatch) |
| fault_addr_o | output | 64 | Address of the last trapped access |
| async_fault_o | output | 1 | Sticky asynchronous mismatch flag |

## Verification
Two things can happen in the same cycle: clearing the sticky flag and accepting a new asynchronous mismatch that would set it. The bench provokes this by raising async_clr_i in the very cycle a mismatching asynchronous access is accepted. It then expects the flag to read 1. A lone clear in the next cycle must bring the flag to 0. A second overlap comes when a tag-set and an access are requested in the same idle cycle. The access must be judged against the tags as they stood before the command, and the bench watches the responses that follow while busy holds new requests off.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int unsigned ADDR_W   = 64;
  localparam int unsigned TAG_W    = 4;
  localparam int unsigned TAG_LSB  = 56;
  localparam int unsigned GRAN_LOG = 4;
  localparam int unsigned NUM_GRAN = 64;
  localparam int unsigned IDX_W    = $clog2(NUM_GRAN);
  localparam int unsigned OFS_W    = GRAN_LOG + IDX_W;
  localparam int unsigned SIZE_W   = 12;
  localparam int unsigned CNT_W    = SIZE_W - GRAN_LOG + 2;

  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic valid;
    logic ok;
    logic fault;
  } rsp_t;
endpackage

// File: rtl/tcu_tag_store.sv
module tcu_tag_store
  import tcu_pkg::*;
#(
  parameter int unsigned N  = NUM_GRAN,
  parameter int unsigned IW = $clog2(N),
  parameter int unsigned TW = TAG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [TW-1:0] wr_tag_i,
  input  logic [IW-1:0] rd_a_idx_i,
  input  logic [IW-1:0] rd_b_idx_i,
  output logic [TW-1:0] rd_a_tag_o,
  output logic [TW-1:0] rd_b_tag_o
);
  logic [TW-1:0] mem_q [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IW'(g))        mem_q[g] <= wr_tag_i;
    end
  end

  assign rd_a_tag_o = mem_q[rd_a_idx_i];
  assign rd_b_tag_o = mem_q[rd_b_idx_i];
endmodule

// File: rtl/tcu_fill.sv
module tcu_fill
  import tcu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_valid_i,
  input  logic [OFS_W-1:0]  set_base_i,
  input  logic [SIZE_W-1:0] set_bytes_i,
  input  tag_t              set_tag_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output idx_t              wr_idx_o,
  output tag_t              wr_tag_o
);
  logic [CNT_W-1:0] cnt_q;
  idx_t             ptr_q;
  tag_t             tag_q;
  logic [SIZE_W+1:0] span;
  logic             start;

  // granules covering [base, base+bytes) from the base offset inside its granule
  assign span  = (SIZE_W+2)'(set_base_i[GRAN_LOG-1:0]) + (SIZE_W+2)'(set_bytes_i)
               + (SIZE_W+2)'((1 << GRAN_LOG) - 1);
  assign start = set_valid_i && !busy_o && (set_bytes_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ptr_q <= '0;
      tag_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_W'(span >> GRAN_LOG);
      ptr_q <= set_base_i[OFS_W-1:GRAN_LOG];
      tag_q <= set_tag_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign wr_en_o  = busy_o;
  assign wr_idx_o = ptr_q;
  assign wr_tag_o = tag_q;
endmodule

// File: rtl/tcu_compare.sv
module tcu_compare
  import tcu_pkg::*;
(
  input  logic [OFS_W-1:0]    ofs_i,
  input  logic [GRAN_LOG-1:0] len_i,
  input  tag_t                ptr_tag_i,
  input  tag_t                tag_a_i,
  input  tag_t                tag_b_i,
  output idx_t                idx_a_o,
  output idx_t                idx_b_o,
  output logic                mismatch_o
);
  logic [GRAN_LOG:0] last_byte;
  logic              crosses;

  assign last_byte  = {1'b0, ofs_i[GRAN_LOG-1:0]} + {1'b0, len_i};
  assign crosses    = last_byte[GRAN_LOG];
  assign idx_a_o    = ofs_i[OFS_W-1:GRAN_LOG];
  assign idx_b_o    = idx_a_o + 1'b1;
  assign mismatch_o = (tag_a_i != ptr_tag_i) || (crosses && (tag_b_i != ptr_tag_i));
endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit
  import tcu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sync_mode_i,
  input  logic              async_clr_i,
  input  logic              set_valid_i,
  input  logic [OFS_W-1:0]  set_base_i,
  input  logic [SIZE_W-1:0] set_bytes_i,
  input  logic [TAG_W-1:0]  set_tag_i,
  output logic              set_busy_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [GRAN_LOG-1:0] req_len_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_fault_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic              async_fault_o
);
  logic wr_en;
  idx_t wr_idx, idx_a, idx_b;
  tag_t wr_tag, tag_a, tag_b;
  logic mismatch, accept, trap, flag_set;
  rsp_t rsp_q;
  logic [ADDR_W-1:0] fault_addr_q;
  logic flag_q;

  tcu_fill u_fill (
    .clk_i, .rst_ni,
    .set_valid_i, .set_base_i, .set_bytes_i, .set_tag_i,
    .busy_o(set_busy_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_tag_o(wr_tag)
  );

  tcu_tag_store u_store (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag),
    .rd_a_idx_i(idx_a), .rd_b_idx_i(idx_b),
    .rd_a_tag_o(tag_a), .rd_b_tag_o(tag_b)
  );

  tcu_compare u_cmp (
    .ofs_i(req_addr_i[OFS_W-1:0]), .len_i(req_len_i),
    .ptr_tag_i(req_addr_i[TAG_LSB +: TAG_W]),
    .tag_a_i(tag_a), .tag_b_i(tag_b),
    .idx_a_o(idx_a), .idx_b_o(idx_b), .mismatch_o(mismatch)
  );

  assign req_ready_o = !set_busy_o;
  assign accept      = req_valid_i && req_ready_o;
  assign trap        = accept && en_i && sync_mode_i && mismatch;
  assign flag_set    = accept && en_i && !sync_mode_i && mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q        <= '0;
      fault_addr_q <= '0;
      flag_q       <= 1'b0;
    end else begin
      rsp_q.valid <= accept;
      rsp_q.ok    <= accept && !trap;
      rsp_q.fault <= trap;
      if (trap)             fault_addr_q <= req_addr_i;
      if (flag_set)         flag_q <= 1'b1;
      else if (async_clr_i) flag_q <= 1'b0;
    end
  end

  assign rsp_valid_o   = rsp_q.valid;
  assign rsp_ok_o      = rsp_q.ok;
  assign rsp_fault_o   = rsp_q.fault;
  assign fault_addr_o  = fault_addr_q;
  assign async_fault_o = flag_q;
endmodule

// File: rtl/tcu_sva.sv
module tcu_sva
  import tcu_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              sync_mode_i,
  input logic              async_clr_i,
  input logic              set_busy_o,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              rsp_fault_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic              async_fault_o
);
  p_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_busy_o |=> !rsp_valid_o);

  p_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_busy_o |-> !req_ready_o);

  p_one_outcome_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_ok_o != rsp_fault_o));

  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> (!rsp_ok_o && !rsp_fault_o));

  p_fault_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> fault_addr_o == $past(req_addr_i));

  p_async_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !sync_mode_i) |=> rsp_ok_o);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (async_fault_o && !async_clr_i) |=> async_fault_o);

  p_off_ok_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !en_i) |=> (rsp_ok_o && !rsp_fault_o));

  p_off_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!async_fault_o && !en_i) |=> !async_fault_o);
endmodule

bind tag_check_unit tcu_sva u_sva (
  .clk_i, .rst_ni, .en_i, .sync_mode_i, .async_clr_i, .set_busy_o,
  .req_valid_i, .req_addr_i, .req_ready_o, .rsp_valid_o, .rsp_ok_o,
  .rsp_fault_o, .fault_addr_o, .async_fault_o
);

// File: tb/sim_tag_check_unit.sv
module sim_tag_check_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 0, rst_ni = 0;
  logic        en_i = 1, sync_mode_i = 1, async_clr_i = 0;
  logic        set_valid_i = 0;
  logic [9:0]  set_base_i = '0;
  logic [11:0] set_bytes_i = '0;
  logic [3:0]  set_tag_i = '0;
  logic        set_busy_o;
  logic        req_valid_i = 0;
  logic [63:0] req_addr_i = '0;
  logic [3:0]  req_len_i = '0;
  logic        req_ready_o, rsp_valid_o, rsp_ok_o, rsp_fault_o, async_fault_o;
  logic [63:0] fault_addr_o;

  int checks = 0, fails = 0;
  bit done = 0;

  tag_check_unit u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {addr[63:0], len[3:0], expect_fault}
  localparam int NV = 9;
  localparam logic [68:0] VEC [NV] = '{
    {64'h0500_0000_0000_0000, 4'd15, 1'b0},   // R5 granule 0
    {64'h0500_0000_0000_0038, 4'd7,  1'b0},   // R10 gran 3 off 8 to end
    {64'h0900_0000_0000_0040, 4'd0,  1'b0},   // R5 gran 4 tag 9
    {64'h0500_0000_0000_003C, 4'd7,  1'b1},   // R9 crosses into gran 4
    {64'h0500_0000_0000_0044, 4'd1,  1'b1},   // R6 wrong tag
    {64'h0000_0000_0000_0050, 4'd3,  1'b0},   // R1 untouched gran 5
    {64'hA500_0000_0000_0010, 4'd15, 1'b0},   // R2 upper nibble ignored
    {64'h0500_0000_0010_0018, 4'd3,  1'b0},   // R2 high index bits ignored
    {64'h0500_0000_0000_0030, 4'd15, 1'b0}    // R10 full granule
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [63:0] a, input logic [3:0] l);
    req_addr_i = a; req_len_i = l; req_valid_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
  endtask

  task automatic tag_set(input logic [9:0] b, input logic [11:0] n, input logic [3:0] t,
                         output int busy_cycles);
    set_base_i = b; set_bytes_i = n; set_tag_i = t; set_valid_i = 1;
    @(negedge clk_i);
    set_valid_i = 0;
    busy_cycles = 0;
    while (set_busy_o && busy_cycles < 1000) begin
      busy_cycles++;
      @(negedge clk_i);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk_i);
    chk("R1 busy", 64'(set_busy_o), 0);
    chk("R1 flag", 64'(async_fault_o), 0);
    chk("R1 rsp_valid", 64'(rsp_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    access(64'h0000_0000_0000_0120, 4'd3);
    chk("R1 tag0 ok", 64'(rsp_ok_o), 1);

    tag_set(10'h000, 12'd50, 4'd5, bc);
    chk("R3 busy cycles 50B", 64'(bc), 4);
    tag_set(10'h040, 12'd1, 4'd9, bc);
    chk("R3 busy cycles 1B", 64'(bc), 1);
    tag_set(10'h0A0, 12'd0, 4'd3, bc);
    chk("R3 zero size", 64'(bc), 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][68:5], VEC[i][4:1]);
      chk("R5 rsp_valid", 64'(rsp_valid_o), 1);
      chk(VEC[i][0] ? "R6 fault" : "R5 ok", 64'(rsp_fault_o), 64'(VEC[i][0]));
      chk("R6 ok flag", 64'(rsp_ok_o), 64'(!VEC[i][0]));
      if (VEC[i][0]) chk("R6 fault addr", fault_addr_o, VEC[i][68:5]);
    end

    // R3 unaligned base: offset 0x68 + 16 bytes covers granules 6 and 7
    tag_set(10'h068, 12'd16, 4'd2, bc);
    chk("R3 unaligned span", 64'(bc), 2);
    access(64'h0200_0000_0000_0070, 4'd0);
    chk("R3 gran7 tagged", 64'(rsp_ok_o), 1);

    // R4 stall while busy
    set_base_i = 10'h100; set_bytes_i = 12'd48; set_tag_i = 4'd1; set_valid_i = 1;
    req_addr_i = 64'h0500_0000_0000_0000; req_len_i = 0; req_valid_i = 1;
    @(negedge clk_i);
    set_valid_i = 0;
    chk("R4 same-cycle access uses old tags", 64'(rsp_ok_o), 1);
    chk("R4 ready low", 64'(req_ready_o), 0);
    @(negedge clk_i);
    chk("R4 no response while busy", 64'(rsp_valid_o), 0);
    req_valid_i = 0;
    while (set_busy_o) @(negedge clk_i);

    // R7 async mismatch completes, sets flag
    sync_mode_i = 0;
    access(64'h0700_0000_0000_0000, 4'd0);
    chk("R7 ok", 64'(rsp_ok_o), 1);
    chk("R7 flag", 64'(async_fault_o), 1);
    @(negedge clk_i);
    chk("R8 sticky", 64'(async_fault_o), 1);
    // R8 clear coinciding with new mismatch: set wins
    async_clr_i = 1;
    access(64'h0700_0000_0000_0000, 4'd0);
    chk("R8 set beats clear", 64'(async_fault_o), 1);
    @(negedge clk_i);
    async_clr_i = 0;
    chk("R8 cleared", 64'(async_fault_o), 0);

    // R11 disabled
    en_i = 0;
    access(64'h0700_0000_0000_0000, 4'd0);
    chk("R11 flag stays low", 64'(async_fault_o), 0);
    sync_mode_i = 1;
    access(64'h0700_0000_0000_0000, 4'd0);
    chk("R11 no trap", 64'(rsp_fault_o), 0);
    chk("R11 ok", 64'(rsp_ok_o), 1);
    en_i = 1;

    // R12 wrap
    tag_set(10'h3F0, 12'd32, 4'd7, bc);
    chk("R12 busy", 64'(bc), 2);
    access(64'h0700_0000_0000_0004, 4'd0);
    chk("R12 gran0 wrapped", 64'(rsp_ok_o), 1);
    access(64'h0700_0000_0000_03F8, 4'd15);
    chk("R12 cross 63->0", 64'(rsp_fault_o), 0);
    access(64'h0500_0000_0000_0000, 4'd0);
    chk("R12 old tag gone", 64'(rsp_fault_o), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule